// File: doc/BRIEF.md
# Card Command Issue and Staging Unit

This unit sits between a host register port and a card protocol engine. Software writes a command word. The unit decodes that word and picks one of two data paths. Payloads of up to eight bytes go through a pair of 32-bit parameter registers, and the command word carries their length. Larger payloads use a block register and a 32-bit data port that fronts a small FIFO. The unit then presents a descriptor to the protocol engine and holds it until the engine accepts it.

The engine later reports that the command is done and returns the card's status byte. For short reads it also returns the received payload. For FIFO transfers the engine moves words through the FIFO and signals separately when the data phase ends. The unit stays busy until both the command and the data phase have finished. It raises single-cycle events for end of command, end of transfer and a rejected command, and a level event while the FIFO can be served.

Top module: `cmdstage_top`

## Requirements
- R1: After reset the unit is idle: STATUS reads with only bit 9 (FIFO empty) set, no event is raised and no descriptor is offered.
- R2: A command write decodes bits 23:16 as the transfer code, bit 14 as direction (1 = read from card), bit 13 as wait-for-card-interrupt and bit 11 as get-interrupt, and presents these on the descriptor.
- R3: With bit 15 of the command clear, the transfer is short. Its length is the low 4 bits (0 to 8), and the descriptor payload is {PARAM1, PARAM0}, little-endian: byte 0 in PARAM0[7:0], bytes 4 to 7 in PARAM1.
- R4: With bit 15 set, the transfer uses the FIFO. The descriptor carries the block count from BLOCK[31:16] and the byte size from BLOCK[11:0].
- R5: STATUS bit 19 (busy) is set from an accepted command write until the engine reports completion. A FIFO command completes only when both the command end and the data-phase end have been reported, in either order.
- R6: A command write while busy is ignored: the descriptor is unchanged and the error event pulses for one cycle on the next cycle.
- R7: End of command pulses the cycle after the engine's done strobe. The card status byte then reads in STATUS[7:0]. For short reads, PARAM0 and PARAM1 already hold the engine's payload in that cycle.
- R8: End of transfer pulses the cycle after the engine's data-done strobe during a FIFO transfer, and never for a short transfer.
- R9: The FIFO keeps word order. A host DATA write fills it on write transfers, and a host DATA read drains it on read transfers. STATUS bit 9 shows empty and bit 8 shows full, and a push into a full FIFO is dropped.
- R10: The FIFO-ready event is high while a FIFO transfer is active and the FIFO is non-empty (reads) or non-full (writes), and low otherwise.
- R11: Writing zero to BLOCK while a FIFO data phase is pending abandons it. The FIFO is flushed, no end-of-transfer event follows, and command end alone completes the command.
- R12: The descriptor stays valid and stable until the engine accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write register select (0 CMD, 1 PARAM0, 2 PARAM1, 3 BLOCK, 4 DATA) |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe (pops FIFO when rdAddr is DATA) |
| rdAddr | input | 3 | Read register select (5 STATUS) |
| rdData | output | 32 | Read data |
| descValid | output | 1 | Descriptor offered to the engine |
| descReady | input | 1 | Engine accepts descriptor |
| cmdCode | output | 8 | Transfer code |
| cmdRead | output | 1 | Direction, 1 = from card |
| cmdWaitInt | output | 1 | Wait for card interrupt |
| cmdGetInt | output | 1 | Get interrupt |
| cmdShort | output | 1 | Short (parameter-register) path |
| cmdLen | output | 12 | Short length or block byte size |
| cmdBlocks | output | 16 | Block count |
| cmdParam | output | 64 | Short write payload |
| engDone | input | 1 | Engine command done strobe |
| engStatus | input | 8 | Card status byte |
| engParam | input | 64 | Short read payload |
| engXferDone | input | 1 | Engine data phase done strobe |
| engRdPush | input | 1 | Engine pushes a read word |
| engRdData | input | 32 | Read word from engine |
| engWrPop | input | 1 | Engine pops a write word |
| engWrData | output | 32 | FIFO head for the engine |
| evCmdEnd | output | 1 | End of command pulse |
| evXferEnd | output | 1 | End of transfer pulse |
| evCmdErr | output | 1 | Rejected command pulse |
| evFifoRdy | output | 1 | FIFO serviceable level |

## Verification
The assertions check several rules on every cycle. Each end-of-command and end-of-transfer pulse must trace back to an engine strobe, a rejection may only occur while busy, FIFO readiness implies busy, and an offered descriptor must hold still until it is taken. Other behaviour needs the bench's scenarios. These cover the little-endian payload placement, the decode of block count and size, FIFO word order and the dropping of overflow pushes. They also cover completion in either order of command and data end, and the abandon sequence leaving no end-of-transfer event.

// File: rtl/cmdstage_pkg.sv
package cmdstage_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_PAR0 = 3'd1;
  localparam logic [ADDR_W-1:0] REG_PAR1 = 3'd2;
  localparam logic [ADDR_W-1:0] REG_BLK  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_DATA = 3'd4;
  localparam logic [ADDR_W-1:0] REG_STAT = 3'd5;
  localparam int BIT_FIFOPATH = 15;
  localparam int BIT_READ     = 14;
  localparam int BIT_WAITINT  = 13;
  localparam int BIT_GETINT   = 11;

  typedef struct packed {
    logic issue;
    logic loadPar;
    logic latchStat;
    logic flush;
  } strobes_t;
endpackage

// File: rtl/cmdstage_fifo.sv
module cmdstage_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/cmdstage_ctrl.sv
module cmdstage_ctrl
  import cmdstage_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              descReady,
  input  logic              engDone,
  input  logic              engXferDone,
  output logic              busy,
  output logic              descValid,
  output logic              fifoActive,
  output strobes_t          strobes,
  output logic              evCmdEnd,
  output logic              evXferEnd,
  output logic              evCmdErr
);
  logic isShort, isRead, cmdDone, dataDone;
  logic cmdWr, issue, abandon, xferHit, cmdNext, dataNext;

  assign cmdWr      = wrEn && (wrAddr == REG_CMD);
  assign issue      = cmdWr && !busy;
  assign fifoActive = busy && !isShort && !dataDone;
  assign abandon    = wrEn && (wrAddr == REG_BLK) && (wrData == '0) && fifoActive;
  assign xferHit    = fifoActive && engXferDone;
  assign cmdNext    = cmdDone || (busy && engDone);
  assign dataNext   = dataDone || xferHit || abandon;

  always_comb begin
    strobes.issue     = issue;
    strobes.loadPar   = busy && engDone && isShort && isRead;
    strobes.latchStat = busy && engDone;
    strobes.flush     = issue || abandon;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      isShort   <= 1'b0;
      isRead    <= 1'b0;
      cmdDone   <= 1'b0;
      dataDone  <= 1'b0;
      descValid <= 1'b0;
      evCmdEnd  <= 1'b0;
      evXferEnd <= 1'b0;
      evCmdErr  <= 1'b0;
    end else begin
      evCmdEnd  <= busy && engDone;
      evXferEnd <= xferHit;
      evCmdErr  <= cmdWr && busy;
      if (issue) begin
        busy      <= 1'b1;
        isShort   <= !wrData[BIT_FIFOPATH];
        isRead    <= wrData[BIT_READ];
        cmdDone   <= 1'b0;
        dataDone  <= !wrData[BIT_FIFOPATH];
        descValid <= 1'b1;
      end else begin
        if (descReady) descValid <= 1'b0;
        if (busy) begin
          if (cmdNext && dataNext) begin
            busy     <= 1'b0;
            cmdDone  <= 1'b0;
            dataDone <= 1'b0;
          end else begin
            cmdDone  <= cmdNext;
            dataDone <= dataNext;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cmdstage_dp.sv
module cmdstage_dp
  import cmdstage_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  strobes_t            strobes,
  input  logic                busy,
  input  logic                fifoActive,
  input  logic [7:0]          engStatus,
  input  logic [2*DATA_W-1:0] engParam,
  input  logic                engRdPush,
  input  logic [DATA_W-1:0]   engRdData,
  input  logic                engWrPop,
  output logic [DATA_W-1:0]   engWrData,
  output logic [7:0]          cmdCode,
  output logic                cmdRead,
  output logic                cmdWaitInt,
  output logic                cmdGetInt,
  output logic                cmdShort,
  output logic [11:0]         cmdLen,
  output logic [15:0]         cmdBlocks,
  output logic [2*DATA_W-1:0] cmdParam,
  output logic                evFifoRdy
);
  logic [DATA_W-1:0] cmdWord, par0, par1, blkReg, descBlk;
  logic [7:0] cardStat;
  logic fifoEmpty, fifoFull, hostPush, engPush, hostPop, engPop;
  logic [DATA_W-1:0] head;

  assign cmdRead    = cmdWord[BIT_READ];
  assign cmdCode    = cmdWord[23:16];
  assign cmdWaitInt = cmdWord[BIT_WAITINT];
  assign cmdGetInt  = cmdWord[BIT_GETINT];
  assign cmdShort   = !cmdWord[BIT_FIFOPATH];
  assign cmdLen     = cmdShort ? {8'd0, cmdWord[3:0]} : descBlk[11:0];
  assign cmdBlocks  = descBlk[31:16];

  assign hostPush = wrEn && (wrAddr == REG_DATA) && fifoActive && !cmdRead;
  assign engPush  = engRdPush && fifoActive && cmdRead;
  assign hostPop  = rdEn && (rdAddr == REG_DATA) && fifoActive && cmdRead;
  assign engPop   = engWrPop && fifoActive && !cmdRead;
  assign engWrData = head;
  assign evFifoRdy = fifoActive && (cmdRead ? !fifoEmpty : !fifoFull);

  cmdstage_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .flush(strobes.flush),
    .push(hostPush || engPush), .pushData(cmdRead ? engRdData : wrData),
    .pop(hostPop || engPop), .head(head), .empty(fifoEmpty), .full(fifoFull));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord  <= '0;
      par0     <= '0;
      par1     <= '0;
      blkReg   <= '0;
      descBlk  <= '0;
      cmdParam <= '0;
      cardStat <= '0;
    end else begin
      if (strobes.issue) begin
        cmdWord  <= wrData;
        descBlk  <= blkReg;
        cmdParam <= {par1, par0};
      end
      if (strobes.loadPar) begin
        par0 <= engParam[DATA_W-1:0];
        par1 <= engParam[2*DATA_W-1:DATA_W];
      end else if (wrEn && wrAddr == REG_PAR0) begin
        par0 <= wrData;
      end else if (wrEn && wrAddr == REG_PAR1) begin
        par1 <= wrData;
      end
      if (wrEn && wrAddr == REG_BLK) blkReg <= wrData;
      if (strobes.latchStat) cardStat <= engStatus;
    end
  end

  always_comb begin
    case (rdAddr)
      REG_CMD:  rdData = cmdWord;
      REG_PAR0: rdData = par0;
      REG_PAR1: rdData = par1;
      REG_BLK:  rdData = blkReg;
      REG_DATA: rdData = (fifoActive && cmdRead) ? head : '0;
      REG_STAT: rdData = DATA_W'({12'd0, busy, 9'd0, fifoEmpty, fifoFull, cardStat});
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/cmdstage_top.sv
module cmdstage_top
  import cmdstage_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdEn,
  input  logic [2:0]          rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                descValid,
  input  logic                descReady,
  output logic [7:0]          cmdCode,
  output logic                cmdRead,
  output logic                cmdWaitInt,
  output logic                cmdGetInt,
  output logic                cmdShort,
  output logic [11:0]         cmdLen,
  output logic [15:0]         cmdBlocks,
  output logic [2*DATA_W-1:0] cmdParam,
  input  logic                engDone,
  input  logic [7:0]          engStatus,
  input  logic [2*DATA_W-1:0] engParam,
  input  logic                engXferDone,
  input  logic                engRdPush,
  input  logic [DATA_W-1:0]   engRdData,
  input  logic                engWrPop,
  output logic [DATA_W-1:0]   engWrData,
  output logic                evCmdEnd,
  output logic                evXferEnd,
  output logic                evCmdErr,
  output logic                evFifoRdy
);
  strobes_t strobes;
  logic busy, fifoActive;

  cmdstage_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .descReady(descReady), .engDone(engDone), .engXferDone(engXferDone),
    .busy(busy), .descValid(descValid), .fifoActive(fifoActive),
    .strobes(strobes), .evCmdEnd(evCmdEnd), .evXferEnd(evXferEnd),
    .evCmdErr(evCmdErr));

  cmdstage_dp #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .strobes(strobes),
    .busy(busy), .fifoActive(fifoActive), .engStatus(engStatus),
    .engParam(engParam), .engRdPush(engRdPush), .engRdData(engRdData),
    .engWrPop(engWrPop), .engWrData(engWrData), .cmdCode(cmdCode),
    .cmdRead(cmdRead), .cmdWaitInt(cmdWaitInt), .cmdGetInt(cmdGetInt),
    .cmdShort(cmdShort), .cmdLen(cmdLen), .cmdBlocks(cmdBlocks),
    .cmdParam(cmdParam), .evFifoRdy(evFifoRdy));
endmodule

// File: rtl/cmdstage_chk.sv
module cmdstage_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       descValid,
  input logic       descReady,
  input logic [7:0] cmdCode,
  input logic       cmdShort,
  input logic       engDone,
  input logic       engXferDone,
  input logic       evCmdEnd,
  input logic       evXferEnd,
  input logic       evCmdErr,
  input logic       evFifoRdy
);
  assert_cmd_end_follows_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    evCmdEnd |-> $past(engDone) && $past(busy));
  assert_xfer_end_fifo_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    evXferEnd |-> $past(engXferDone) && !cmdShort);
  assert_reject_only_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    evCmdErr |-> $past(busy));
  assert_fifo_rdy_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    evFifoRdy |-> busy);
  assert_desc_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid && $stable(cmdCode));
  assert_desc_needs_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(descValid) |-> busy);
endmodule

bind cmdstage_top cmdstage_chk u_chk (.*);

// File: tb/tb_cmdstage_top.sv
module tb_cmdstage_top;
  localparam int DEPTH = 4;
  logic clk = 0, rstN = 0;
  logic wrEn = 0, rdEn = 0, descReady = 1, engDone = 0, engXferDone = 0;
  logic engRdPush = 0, engWrPop = 0;
  logic [2:0] wrAddr = 0, rdAddr = 0;
  logic [31:0] wrData = 0, engRdData = 0, rdData, engWrData;
  logic [7:0] engStatus = 0, cmdCode;
  logic [63:0] engParam = 0, cmdParam;
  logic descValid, cmdRead, cmdWaitInt, cmdGetInt, cmdShort;
  logic [11:0] cmdLen;
  logic [15:0] cmdBlocks;
  logic evCmdEnd, evXferEnd, evCmdErr, evFifoRdy;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  cmdstage_top dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStat(logic b, logic e, logic f, logic [7:0] s);
    return {12'd0, b, 9'd0, e, f, s};
  endfunction

  function automatic logic [31:0] mkCmd(logic [7:0] code, logic fifo, logic rd,
                                        logic w, logic g, logic [3:0] len);
    return {8'd0, code, fifo, rd, w, 1'b0, g, 7'd0, len};
  endfunction

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic regRead(logic [2:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic pulseDone(logic [7:0] s, logic [63:0] p);
    @(negedge clk); engDone = 1; engStatus = s; engParam = p;
    @(negedge clk); engDone = 0;
  endtask

  task automatic pulseXfer();
    @(negedge clk); engXferDone = 1;
    @(negedge clk); engXferDone = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] r;
    logic [7:0] code, st;
    logic [3:0] len;
    logic [31:0] p0, p1, w [DEPTH];
    logic [63:0] ep;
    r = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    regRead(3'd5, r);
    check("R1 status", r, expStat(0, 1, 0, 0));
    check("R1 events", {descValid, evCmdEnd, evXferEnd, evCmdErr, evFifoRdy}, 0);

    // R3/R2/R7 random short writes
    for (int i = 0; i < 12; i++) begin
      code = 8'($urandom); len = 4'($urandom % 9); p0 = $urandom; p1 = $urandom;
      st = 8'($urandom);
      regWrite(3'd1, p0);
      regWrite(3'd2, p1);
      regWrite(3'd0, mkCmd(code, 0, 0, i[0], i[1], len));
      check("R2 code", cmdCode, code);
      check("R2 flags", {cmdRead, cmdWaitInt, cmdGetInt}, {1'b0, i[0], i[1]});
      check("R3 short len", {cmdShort, cmdLen}, {1'b1, 8'd0, len});
      check("R3 payload", cmdParam, {p1, p0});
      regRead(3'd5, r);
      check("R5 busy", r[19], 1);
      pulseDone(st, 64'h0);
      check("R7 cmd end", evCmdEnd, 1);
      check("R8 no xfer end short", evXferEnd, 0);
      regRead(3'd5, r);
      check("R7 status byte", r, expStat(0, 1, 0, st));
    end

    // R3 little-endian byte placement, directed
    regWrite(3'd1, 32'h33221100);
    regWrite(3'd2, 32'h77665544);
    regWrite(3'd0, mkCmd(8'h2d, 0, 0, 0, 0, 4'd8));
    check("R3 byte0", cmdParam[7:0], 8'h00);
    check("R3 byte4", cmdParam[39:32], 8'h44);
    // R6 write while busy ignored
    regWrite(3'd0, mkCmd(8'h99, 1, 1, 0, 0, 0));
    check("R6 err pulse", evCmdErr, 1);
    check("R6 code unchanged", {cmdCode, cmdShort}, {8'h2d, 1'b1});
    @(negedge clk);
    check("R6 err one cycle", evCmdErr, 0);
    pulseDone(8'h80, 0);

    // R7 short read loads params before cmd end
    for (int i = 0; i < 4; i++) begin
      ep = {$urandom, $urandom};
      regWrite(3'd0, mkCmd(8'($urandom), 0, 1, 0, 0, 4'd8));
      check("R2 read dir", cmdRead, 1);
      pulseDone(8'h21, ep);
      check("R7 end", evCmdEnd, 1);
      regRead(3'd1, r);
      check("R7 par0", r, ep[31:0]);
      regRead(3'd2, r);
      check("R7 par1", r, ep[63:32]);
    end

    // R12 handshake hold
    descReady = 0;
    regWrite(3'd3, {16'd3, 4'd0, 12'd16});
    regWrite(3'd0, mkCmd(8'h4b, 1, 0, 0, 0, 0));
    @(negedge clk);
    check("R12 hold", {descValid, cmdCode}, {1'b1, 8'h4b});
    check("R4 blocks", cmdBlocks, 16'd3);
    check("R4 size", {cmdShort, cmdLen}, {1'b0, 12'd16});
    descReady = 1;
    @(negedge clk);
    check("R12 accepted", descValid, 0);
    // R9/R10 fill FIFO
    check("R10 rdy write", evFifoRdy, 1);
    for (int i = 0; i < DEPTH; i++) begin w[i] = $urandom; regWrite(3'd4, w[i]); end
    regWrite(3'd4, 32'hdeadbeef);
    regRead(3'd5, r);
    check("R9 full", r, expStat(1, 0, 1, 8'h21));
    check("R10 not rdy full", evFifoRdy, 0);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      check("R9 order", engWrData, w[i]);
      engWrPop = 1;
      @(negedge clk); engWrPop = 0;
    end
    regRead(3'd5, r);
    check("R9 empty", r[9:8], 2'b10);
    pulseXfer();
    check("R8 xfer end", evXferEnd, 1);
    regRead(3'd5, r);
    check("R5 busy until cmd end", r[19], 1);
    pulseDone(8'h80, 0);
    regRead(3'd5, r);
    check("R5 idle", r[19], 0);

    // FIFO read, cmd end first
    regWrite(3'd0, mkCmd(8'h02, 1, 1, 0, 0, 0));
    check("R10 empty read", evFifoRdy, 0);
    for (int i = 0; i < 3; i++) begin
      w[i] = $urandom;
      @(negedge clk); engRdPush = 1; engRdData = w[i];
      @(negedge clk); engRdPush = 0;
    end
    check("R10 rdy read", evFifoRdy, 1);
    for (int i = 0; i < 3; i++) begin
      regRead(3'd4, r);
      check("R9 read order", r, w[i]);
      @(negedge clk); rdEn = 1;
      @(negedge clk); rdEn = 0;
    end
    pulseDone(8'h01, 0);
    regRead(3'd5, r);
    check("R5 waits data", r[19], 1);
    pulseXfer();
    regRead(3'd5, r);
    check("R5 both done", r, expStat(0, 1, 0, 8'h01));

    // R11 abandon
    regWrite(3'd3, {16'd1, 4'd0, 12'd8});
    regWrite(3'd0, mkCmd(8'h03, 1, 0, 0, 0, 0));
    regWrite(3'd4, 32'h1);
    regWrite(3'd4, 32'h2);
    regWrite(3'd3, 32'h0);
    regRead(3'd5, r);
    check("R11 flushed", r, expStat(1, 1, 0, 8'h01));
    check("R11 not rdy", evFifoRdy, 0);
    pulseXfer();
    check("R11 no xfer end", evXferEnd, 0);
    pulseDone(8'h40, 0);
    regRead(3'd5, r);
    check("R11 complete", r, expStat(0, 1, 0, 8'h40));
    summary();
  end
endmodule